// File: doc/BRIEF.md
# Set-Associative Instruction Fetch Cache

This block sits between an instruction fetch unit and a word-wide memory port. Each accepted fetch names a 32-bit byte address. The address is split into a word offset, a set index and a tag. The tag is compared against every way of the indexed set. A hit returns the stored word after a fixed, parameterised latency. A miss claims a victim way and writes the new tag into it. It then reads the whole line from memory one word at a time, starting at the requested word and wrapping around the end of the line. The fetch is answered once the line is complete.

A fetch skips the cache entirely in three cases: the cache is marked absent, the cache is switched off, or the fetch carries the inhibit flag. Such a fetch becomes one memory read and leaves every tag, valid bit and usage counter as it was. A separate port invalidates lines by line address. Its effect depends on the cache state: when enabled, only matching ways are cleared; when present but disabled, the whole set is cleared; when absent, nothing happens. Victims are chosen by a per-way saturating usage counter, and the block pulses an event output on every hit and on every miss.

Top module: `icache_ctrl`

## Requirements
- R1: After reset no entry is valid. `f_ready` is 1 and `m_req`, `f_rvalid` and `inv_ack` are 0. The first cached fetch to any address misses, and this includes an address whose tag is zero.
- R2: A fetch is served directly from memory when `cache_present`=0, `cache_enable`=0 or `f_inhibit`=1. In that case there is exactly one memory read at the unmodified fetch address. `f_rvalid`, `f_rdata`=`m_rdata` and `f_err`=`m_err` appear in the cycle of `m_ack`. No hit or miss event is raised and no cache state changes.
- R3: A hit raises `ev_hit` in the first cycle after acceptance and makes no memory request. It returns the addressed word with `f_rvalid` exactly HIT_LAT cycles after the accepting clock edge.
- R4: A miss raises `ev_miss` in the first cycle after acceptance. It then issues LINE_BYTES/4 word reads. Read i goes to the line base plus 4·((w+i) mod LINE_BYTES/4), where w is the word offset of the fetch address (bits [OFF-1:2]).
- R5: After a complete refill, `f_rvalid` is asserted in the cycle after the last `m_ack` and carries the requested word. Every fetch produces exactly one single-cycle response.
- R6: The set index is taken from address bits [OFF+log2(NSETS)-1:OFF], with OFF=log2(LINE_BYTES). The tag is all bits above the set index. Addresses that share a set but differ in tag occupy different ways.
- R7: The victim is the way with the smallest usage count, and the lowest-numbered way wins a tie. A hit sets the hit way's count to USTATES-1 and decrements every way in the set whose count is greater. A miss sets the victim's count to USTATES-1 and decrements every other non-zero count.
- R8: If `m_err` accompanies `m_ack` during a refill, the refill stops and the fetch is answered in that same cycle with `f_err`=1 and `f_rdata`=0. The way being filled becomes invalid and its usage count is cleared.
- R9: An invalidate while the cache is enabled clears only the way of the indexed set whose tag matches. Other ways keep their lines.
- R10: An invalidate while the cache is present but disabled clears every way of the indexed set, whatever the tag.
- R11: An invalidate is taken only when no fetch is in progress, and `inv_ack` pulses in the cycle it takes effect. A request raised during a refill waits until the fetch has been answered. While an invalidate is pending in idle, `f_ready` is 0.
- R12: An invalidate while `cache_present`=0 is acknowledged but changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_present | input | 1 | Cache exists; 0 forces direct memory access |
| cache_enable | input | 1 | Cache switched on |
| f_valid | input | 1 | Fetch request |
| f_ready | output | 1 | Fetch may be accepted this cycle |
| f_addr | input | 32 | Fetch byte address |
| f_inhibit | input | 1 | Fetch must not use the cache |
| f_rvalid | output | 1 | Fetch response valid (one cycle) |
| f_rdata | output | 32 | Fetched word |
| f_err | output | 1 | Fetch ended with a memory error |
| m_req | output | 1 | Memory word read request, held until acknowledged |
| m_addr | output | 32 | Memory read byte address |
| m_ack | input | 1 | Memory read complete this cycle |
| m_rdata | input | 32 | Memory read word, valid with `m_ack` |
| m_err | input | 1 | Memory read failed, valid with `m_ack` |
| inv_req | input | 1 | Invalidate request, held until `inv_ack` |
| inv_line | input | 32-log2(LINE_BYTES) | Line address to invalidate (byte address without the line offset) |
| inv_ack | output | 1 | Invalidate performed this cycle |
| ev_hit | output | 1 | Hit event pulse |
| ev_miss | output | 1 | Miss event pulse |

## Verification
Cycles are counted from the clock edge that accepts the fetch. A hit must answer in cycle HIT_LAT. A refill must answer one cycle after the last acknowledge. A bypass or a refill error must answer in the acknowledge cycle itself. The bench drives acknowledges at the falling edge and samples the response just after, so it records the exact cycle of each acknowledge and of the response and compares their distance with these rules. It checks every refill address against the wrapped order. An invalidate is due in the first idle cycle after the outstanding fetch, and the bench checks for it there and for its absence before that.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int AW = 32;
    localparam int DW = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_HWAIT,
        ST_FILL,
        ST_DELIVER,
        ST_BYPASS
    } ic_state_e;

    typedef struct packed {
        logic          valid;
        logic          err;
        logic [DW-1:0] data;
    } ic_resp_t;

    function automatic int usage_bits(input int ustates);
        return (ustates > 2) ? 2 : 1;
    endfunction

endpackage

// File: rtl/icache_tagdir.sv
module icache_tagdir #(
    parameter int NSETS = 64,
    parameter int NWAYS = 2,
    parameter int TAG_W = 22
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NSETS)-1:0] idx,
    input  logic [TAG_W-1:0]         cmp_tag,
    output logic [NWAYS-1:0]         hit_vec,
    input  logic                     wr_en,
    input  logic [$clog2(NWAYS)-1:0] wr_way,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic                     clr_en,
    input  logic [NWAYS-1:0]         clr_mask
);

    logic [TAG_W-1:0] tags [NSETS][NWAYS];
    logic [NWAYS-1:0] vld  [NSETS];

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld[idx][w] && (tags[idx][w] == cmp_tag);
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[idx][wr_way] <= wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                vld[s] <= '0;
            end
        end else if (wr_en) begin
            vld[idx][wr_way] <= 1'b1;
        end else if (clr_en) begin
            vld[idx] <= vld[idx] & ~clr_mask;
        end
    end

    // R6: a tag lives in at most one way of a set
    a_r6_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

endmodule

// File: rtl/icache_data.sv
module icache_data #(
    parameter int NSETS      = 64,
    parameter int NWAYS      = 2,
    parameter int LINE_BYTES = 16
) (
    input  logic                                clk,
    input  logic                                we,
    input  logic [$clog2(NSETS)-1:0]            set_i,
    input  logic [$clog2(NWAYS)-1:0]            wr_way,
    input  logic [$clog2(LINE_BYTES/4)-1:0]     wr_word,
    input  logic [31:0]                         wr_data,
    input  logic [$clog2(NWAYS)-1:0]            rd_way,
    input  logic [$clog2(LINE_BYTES/4)-1:0]     rd_word,
    output logic [31:0]                         rd_data
);

    localparam int WORDS = LINE_BYTES / 4;
    localparam int DEPTH = NSETS * NWAYS * WORDS;
    localparam int IW    = $clog2(DEPTH);

    logic [31:0] mem [DEPTH];

    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    assign wr_idx  = {set_i, wr_way, wr_word};
    assign rd_idx  = {set_i, rd_way, rd_word};
    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[wr_idx] <= wr_data;
        end
    end

endmodule

// File: rtl/icache_repl.sv
module icache_repl #(
    parameter int NSETS   = 64,
    parameter int NWAYS   = 2,
    parameter int USTATES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(NSETS)-1:0] idx,
    output logic [$clog2(NWAYS)-1:0] victim,
    input  logic                     hit_upd,
    input  logic                     miss_upd,
    input  logic [$clog2(NWAYS)-1:0] upd_way,
    input  logic                     clr_en,
    input  logic [NWAYS-1:0]         clr_mask
);

    localparam int CW    = icache_pkg::usage_bits(USTATES);
    localparam int WAY_W = $clog2(NWAYS);
    localparam int SET_W = $clog2(NSETS);
    localparam logic [CW-1:0] CMAX = CW'(USTATES - 1);

    logic [CW-1:0] cnt [NSETS][NWAYS];

    always_comb begin
        logic [CW-1:0] best;
        best   = CMAX;
        victim = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (cnt[idx][w] < best) begin
                best   = cnt[idx][w];
                victim = WAY_W'(w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                for (int w = 0; w < NWAYS; w++) begin
                    cnt[s][w] <= '0;
                end
            end
        end else if (clr_en) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (clr_mask[w]) cnt[idx][w] <= '0;
            end
        end else if (hit_upd) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (WAY_W'(w) == upd_way)
                    cnt[idx][w] <= CMAX;
                else if (cnt[idx][w] > cnt[idx][upd_way])
                    cnt[idx][w] <= cnt[idx][w] - 1'b1;
            end
        end else if (miss_upd) begin
            for (int w = 0; w < NWAYS; w++) begin
                if (WAY_W'(w) == upd_way)
                    cnt[idx][w] <= CMAX;
                else if (cnt[idx][w] != '0)
                    cnt[idx][w] <= cnt[idx][w] - 1'b1;
            end
        end
    end

    // R7: the way just touched holds the top count one cycle later
    logic             chk_v;
    logic [SET_W-1:0] chk_s;
    logic [WAY_W-1:0] chk_w;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_v <= 1'b0;
            chk_s <= '0;
            chk_w <= '0;
        end else begin
            chk_v <= (hit_upd || miss_upd) && !clr_en;
            chk_s <= idx;
            chk_w <= upd_way;
        end
    end

    a_r7_touched_max: assert property (@(posedge clk) disable iff (rst)
        chk_v |-> (cnt[chk_s][chk_w] == CMAX));

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int NSETS      = 64,
    parameter int NWAYS      = 2,
    parameter int LINE_BYTES = 16,
    parameter int USTATES    = 2,
    parameter int HIT_LAT    = 1
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cache_present,
    input  logic                                 cache_enable,
    input  logic                                 f_valid,
    output logic                                 f_ready,
    input  logic [31:0]                          f_addr,
    input  logic                                 f_inhibit,
    output logic                                 f_rvalid,
    output logic [31:0]                          f_rdata,
    output logic                                 f_err,
    output logic                                 m_req,
    output logic [31:0]                          m_addr,
    input  logic                                 m_ack,
    input  logic [31:0]                          m_rdata,
    input  logic                                 m_err,
    input  logic                                 inv_req,
    input  logic [31-$clog2(LINE_BYTES):0]       inv_line,
    output logic                                 inv_ack,
    output logic                                 ev_hit,
    output logic                                 ev_miss
);

    localparam int WORDS   = LINE_BYTES / 4;
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int WO_W    = $clog2(WORDS);
    localparam int SET_W   = $clog2(NSETS);
    localparam int WAY_W   = $clog2(NWAYS);
    localparam int TAG_W   = AW - OFF_W - SET_W;
    localparam int EFF_LAT = (HIT_LAT < 1) ? 1 : HIT_LAT;
    localparam int HC_W    = $clog2(EFF_LAT + 1) + 1;

    ic_state_e        st;
    logic [AW-1:0]    rq_addr;
    logic [WO_W-1:0]  fcnt;
    logic [WAY_W-1:0] vic_q;
    logic [HC_W-1:0]  hcnt;
    logic [DW-1:0]    hold_q;

    logic [SET_W-1:0] rq_set;
    logic [TAG_W-1:0] rq_tag;
    logic [WO_W-1:0]  rq_word;
    logic [WO_W-1:0]  fill_word;
    logic [SET_W-1:0] inv_set;
    logic [TAG_W-1:0] inv_tag;

    assign rq_set    = rq_addr[OFF_W +: SET_W];
    assign rq_tag    = rq_addr[AW-1 -: TAG_W];
    assign rq_word   = rq_addr[2 +: WO_W];
    assign fill_word = rq_word + fcnt;
    assign inv_set   = inv_line[SET_W-1:0];
    assign inv_tag   = inv_line[AW-OFF_W-1 -: TAG_W];

    logic             idle;
    logic             idle_inv;
    logic             accept;
    logic             go_bypass;
    logic [SET_W-1:0] dir_set;
    logic [TAG_W-1:0] dir_tag;
    logic [NWAYS-1:0] hit_vec;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    logic             dir_wr;
    logic             clr_en;
    logic [NWAYS-1:0] clr_mask;
    logic             fill_ack;
    logic             fill_fail;
    logic             fill_last;
    logic [WAY_W-1:0] rd_way;
    logic [DW-1:0]    rd_word_data;
    ic_resp_t         resp;

    assign idle      = (st == ST_IDLE);
    assign idle_inv  = idle && inv_req;
    assign f_ready   = idle && !inv_req;
    assign inv_ack   = idle_inv;
    assign accept    = f_ready && f_valid;
    assign go_bypass = !cache_present || !cache_enable || f_inhibit;

    assign dir_set = idle ? inv_set : rq_set;
    assign dir_tag = idle ? inv_tag : rq_tag;

    assign hit = |hit_vec;
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < NWAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    assign dir_wr    = (st == ST_LOOKUP) && !hit;
    assign fill_ack  = (st == ST_FILL) && m_ack;
    assign fill_fail = fill_ack && m_err;
    assign fill_last = (fcnt == WO_W'(WORDS - 1));

    always_comb begin
        clr_en   = 1'b0;
        clr_mask = '0;
        if (idle_inv && cache_present) begin
            clr_en   = 1'b1;
            clr_mask = cache_enable ? hit_vec : '1;
        end else if (fill_fail) begin
            clr_en   = 1'b1;
            clr_mask = NWAYS'(1) << vic_q;
        end
    end

    assign rd_way = (st == ST_LOOKUP) ? hit_way : vic_q;

    icache_tagdir #(
        .NSETS (NSETS),
        .NWAYS (NWAYS),
        .TAG_W (TAG_W)
    ) u_tagdir (
        .clk      (clk),
        .rst      (rst),
        .idx      (dir_set),
        .cmp_tag  (dir_tag),
        .hit_vec  (hit_vec),
        .wr_en    (dir_wr),
        .wr_way   (victim),
        .wr_tag   (rq_tag),
        .clr_en   (clr_en),
        .clr_mask (clr_mask)
    );

    icache_repl #(
        .NSETS   (NSETS),
        .NWAYS   (NWAYS),
        .USTATES (USTATES)
    ) u_repl (
        .clk      (clk),
        .rst      (rst),
        .idx      (dir_set),
        .victim   (victim),
        .hit_upd  ((st == ST_LOOKUP) && hit),
        .miss_upd (dir_wr),
        .upd_way  (hit ? hit_way : victim),
        .clr_en   (clr_en),
        .clr_mask (clr_mask)
    );

    icache_data #(
        .NSETS      (NSETS),
        .NWAYS      (NWAYS),
        .LINE_BYTES (LINE_BYTES)
    ) u_data (
        .clk     (clk),
        .we      (fill_ack && !m_err),
        .set_i   (rq_set),
        .wr_way  (vic_q),
        .wr_word (fill_word),
        .wr_data (m_rdata),
        .rd_way  (rd_way),
        .rd_word (rq_word),
        .rd_data (rd_word_data)
    );

    // Response and memory-side outputs
    always_comb begin
        resp   = '0;
        m_req  = 1'b0;
        m_addr = {rq_tag, rq_set, fill_word, 2'b00};
        unique case (st)
            ST_LOOKUP: begin
                if (hit && EFF_LAT == 1) begin
                    resp.valid = 1'b1;
                    resp.data  = rd_word_data;
                end
            end
            ST_HWAIT: begin
                if (hcnt == HC_W'(EFF_LAT - 1)) begin
                    resp.valid = 1'b1;
                    resp.data  = hold_q;
                end
            end
            ST_FILL: begin
                m_req = 1'b1;
                if (fill_fail) begin
                    resp.valid = 1'b1;
                    resp.err   = 1'b1;
                end
            end
            ST_DELIVER: begin
                resp.valid = 1'b1;
                resp.data  = rd_word_data;
            end
            ST_BYPASS: begin
                m_req  = 1'b1;
                m_addr = rq_addr;
                if (m_ack) begin
                    resp.valid = 1'b1;
                    resp.err   = m_err;
                    resp.data  = m_rdata;
                end
            end
            default: ;
        endcase
    end

    assign f_rvalid = resp.valid;
    assign f_err    = resp.err;
    assign f_rdata  = resp.data;
    assign ev_hit   = (st == ST_LOOKUP) && hit;
    assign ev_miss  = dir_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            rq_addr <= '0;
            fcnt    <= '0;
            vic_q   <= '0;
            hcnt    <= '0;
            hold_q  <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        rq_addr <= f_addr;
                        st      <= go_bypass ? ST_BYPASS : ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit) begin
                        if (EFF_LAT == 1) begin
                            st <= ST_IDLE;
                        end else begin
                            hold_q <= rd_word_data;
                            hcnt   <= HC_W'(1);
                            st     <= ST_HWAIT;
                        end
                    end else begin
                        vic_q <= victim;
                        fcnt  <= '0;
                        st    <= ST_FILL;
                    end
                end
                ST_HWAIT: begin
                    if (hcnt == HC_W'(EFF_LAT - 1)) st <= ST_IDLE;
                    else                            hcnt <= hcnt + 1'b1;
                end
                ST_FILL: begin
                    if (m_ack) begin
                        if (m_err)          st <= ST_IDLE;
                        else if (fill_last) st <= ST_DELIVER;
                        else                fcnt <= fcnt + 1'b1;
                    end
                end
                ST_DELIVER: st <= ST_IDLE;
                ST_BYPASS:  if (m_ack) st <= ST_IDLE;
                default:    st <= ST_IDLE;
            endcase
        end
    end

    // R11: invalidates happen only while nothing is outstanding
    a_r11_inv_when_quiet: assert property (@(posedge clk) disable iff (rst)
        inv_ack |-> (!m_req && !f_rvalid));

    // R5: one single-cycle answer per fetch
    a_r5_single_beat: assert property (@(posedge clk) disable iff (rst)
        f_rvalid |=> !f_rvalid);

    // R4: a miss is followed by a refill request
    a_r4_miss_refills: assert property (@(posedge clk) disable iff (rst)
        ev_miss |=> m_req);

    // R3: a hit never touches memory
    a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (rst)
        ev_hit |=> !m_req);

    // R2: a direct access issues one read only
    a_r2_single_read: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_BYPASS) && m_ack) |=> !m_req);

endmodule

// File: tb/icache_ctrl_tb.sv
module icache_ctrl_tb;

    localparam int CLK_P   = 10;
    localparam int NSETS   = 16;
    localparam int NWAYS   = 2;
    localparam int LB      = 16;
    localparam int WORDS   = LB / 4;
    localparam int HIT_LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cache_present = 1'b1;
    logic        cache_enable  = 1'b1;
    logic        f_valid = 1'b0;
    logic        f_ready;
    logic [31:0] f_addr = '0;
    logic        f_inhibit = 1'b0;
    logic        f_rvalid;
    logic [31:0] f_rdata;
    logic        f_err;
    logic        m_req;
    logic [31:0] m_addr;
    logic        m_ack = 1'b0;
    logic [31:0] m_rdata = '0;
    logic        m_err = 1'b0;
    logic        inv_req = 1'b0;
    logic [27:0] inv_line = '0;
    logic        inv_ack;
    logic        ev_hit;
    logic        ev_miss;

    always #(CLK_P/2) clk = ~clk;

    icache_ctrl #(
        .NSETS(NSETS), .NWAYS(NWAYS), .LINE_BYTES(LB), .USTATES(2), .HIT_LAT(HIT_LAT)
    ) u_dut (
        .clk(clk), .rst(rst), .cache_present(cache_present), .cache_enable(cache_enable),
        .f_valid(f_valid), .f_ready(f_ready), .f_addr(f_addr), .f_inhibit(f_inhibit),
        .f_rvalid(f_rvalid), .f_rdata(f_rdata), .f_err(f_err),
        .m_req(m_req), .m_addr(m_addr), .m_ack(m_ack), .m_rdata(m_rdata), .m_err(m_err),
        .inv_req(inv_req), .inv_line(inv_line), .inv_ack(inv_ack),
        .ev_hit(ev_hit), .ev_miss(ev_miss)
    );

    int nchk = 0;
    int nbad = 0;
    bit fin  = 1'b0;

    // results of the last fetch
    logic [31:0] r_data;
    logic        r_err, r_hit, r_miss, r_order_ok, r_inv_early, r_got;
    int          r_nack, r_k, r_last;

    function automatic logic [31:0] memw(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) + 32'h0123_4567;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] a, input logic inh, input bit byp,
                         input int err_at, input int lat, input bit inv_during,
                         input logic [31:0] inv_a);
        int waitc;
        logic [31:0] exp_a;
        @(negedge clk);
        f_valid = 1'b1; f_addr = a; f_inhibit = inh;
        @(posedge clk);
        r_data = '0; r_err = 0; r_hit = 0; r_miss = 0; r_order_ok = 1;
        r_inv_early = 0; r_got = 0; r_nack = 0; r_k = 0; r_last = -1;
        waitc = 0;
        while (!r_got && r_k < 200) begin
            @(negedge clk);
            r_k++;
            f_valid = 1'b0;
            if (inv_during && r_k == 1) begin
                inv_req = 1'b1; inv_line = inv_a[31:4];
            end
            if (ev_hit)  r_hit  = 1;
            if (ev_miss) r_miss = 1;
            m_ack = 1'b0; m_err = 1'b0;
            if (m_req) begin
                if (waitc >= lat) begin
                    if (byp) exp_a = a;
                    else exp_a = (a & ~32'(LB-1)) + 32'((((a >> 2) + 32'(r_nack)) % WORDS) * 4);
                    if (m_addr != exp_a) r_order_ok = 0;
                    m_ack   = 1'b1;
                    m_rdata = memw(m_addr);
                    m_err   = (r_nack == err_at);
                    r_nack++;
                    r_last = r_k;
                    waitc  = 0;
                end else begin
                    waitc++;
                end
            end
            if (inv_req && inv_ack) r_inv_early = 1;
            #1;
            if (f_rvalid) begin
                r_got = 1; r_data = f_rdata; r_err = f_err;
            end
        end
        if (!r_got) begin
            nchk++; nbad++;
            $display("FAIL watchdog fetch %h hung", a);
        end
        @(posedge clk); #1;
        m_ack = 1'b0; m_err = 1'b0;
    endtask

    task automatic do_inv(input logic [31:0] a);
        @(negedge clk);
        inv_req = 1'b1; inv_line = a[31:4];
        #1;
        chk(inv_ack == 1'b1, "R11 inv_ack in idle", 32'(inv_ack), 1);
        chk(f_ready == 1'b0, "R11 f_ready low while inv pending", 32'(f_ready), 0);
        @(posedge clk); #1;
        inv_req = 1'b0;
    endtask

    // cached fetch checks: mode 0 = expect hit, 1 = expect miss
    task automatic cfetch(input logic [31:0] a, input bit exp_miss, input string tag);
        fetch(a, 1'b0, 1'b0, -1, 1, 1'b0, 32'h0);
        chk(r_data == memw(a), {tag, " data"}, r_data, memw(a));
        if (exp_miss) begin
            chk(r_miss && !r_hit, {tag, " expect miss"}, {r_hit, r_miss}, 32'h1);
            chk(r_nack == WORDS && r_order_ok, "R4 refill count/order", 32'(r_nack), WORDS);
            chk(r_k == r_last + 1, "R5 answer one cycle after last ack", 32'(r_k), 32'(r_last + 1));
        end else begin
            chk(r_hit && !r_miss, {tag, " expect hit"}, {r_hit, r_miss}, 32'h2);
            chk(r_nack == 0 && r_k == HIT_LAT, "R3 hit latency, no memory", 32'(r_k), HIT_LAT);
        end
    endtask

    localparam logic [31:0] A = 32'h0000_0024;  // set 2, tag 0, word 1
    localparam logic [31:0] B = 32'h0000_1028;  // set 2
    localparam logic [31:0] C = 32'h0000_2020;  // set 2
    localparam logic [31:0] D = 32'h0000_3030;  // set 3
    localparam logic [31:0] E = 32'h0000_0154;  // set 5
    localparam logic [31:0] F = 32'h0000_0254;  // set 5
    localparam logic [31:0] G = 32'h0000_0362;  // set 6
    localparam logic [31:0] H = 32'h0000_0470;  // set 7

    initial begin
        #(CLK_P * 150000);
        if (!fin) begin
            nchk++; nbad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        chk(f_ready == 1 && m_req == 0 && f_rvalid == 0 && inv_ack == 0,
            "R1 reset outputs", {f_ready, m_req, f_rvalid, inv_ack}, 32'h8);

        // R1 tag zero misses, R4 wrapped refill from word 1, R5 delivery
        cfetch(A, 1, "R1 first fetch tag0");
        cfetch(A, 0, "R3 repeat fetch");
        // R6 same set other tag coexists
        cfetch(B, 1, "R6 second tag in set");
        cfetch(A, 0, "R6 first tag still held");
        // R7 victim is the less recently used way (B)
        cfetch(C, 1, "R7 third tag");
        cfetch(A, 0, "R7 recently used survives");
        cfetch(B, 1, "R7 evicted way refetched");

        // R8 refill error on third word
        fetch(D, 1'b0, 1'b0, 2, 1, 1'b0, 32'h0);
        chk(r_err == 1 && r_data == 0, "R8 error response", r_data, 0);
        chk(r_nack == 3 && r_k == r_last, "R8 answered in error ack cycle", 32'(r_k), 32'(r_last));
        cfetch(D, 1, "R8 failed line invalid");

        // R9 enabled invalidate hits matching way only
        cfetch(E, 1, "R9 fill E");
        cfetch(F, 1, "R9 fill F");
        do_inv(32'h0000_0150);
        cfetch(F, 0, "R9 other way kept");
        cfetch(E, 1, "R9 matching way cleared");

        // R12 invalidate with cache absent has no effect
        @(negedge clk); cache_present = 1'b0;
        do_inv(F);
        @(negedge clk); cache_present = 1'b1;
        cfetch(F, 0, "R12 line survives");

        // R2 inhibited fetch goes to memory, leaves no line
        fetch(G, 1'b1, 1'b1, -1, 2, 1'b0, 32'h0);
        chk(r_nack == 1 && r_order_ok && r_data == memw(G) && !r_err,
            "R2 single direct read", r_data, memw(G));
        chk(!r_hit && !r_miss && r_k == r_last, "R2 no events, answer at ack", 32'(r_k), 32'(r_last));
        cfetch(G, 1, "R2 inhibited fetch did not fill");
        @(negedge clk); cache_enable = 1'b0;
        fetch(F, 1'b0, 1'b1, -1, 0, 1'b0, 32'h0);
        chk(r_nack == 1 && !r_hit && r_data == memw(F), "R2 disabled cache bypass", 32'(r_nack), 1);
        fetch(E, 1'b0, 1'b1, 0, 0, 1'b0, 32'h0);
        chk(r_err == 1 && r_data == memw(E), "R2 bypass error passes data", r_data, memw(E));
        @(negedge clk); cache_enable = 1'b1;
        cfetch(F, 0, "R2 disabled fetch kept line");

        // R10 present but disabled: whole set cleared regardless of tag
        @(negedge clk); cache_enable = 1'b0;
        do_inv(32'h7700_0020);
        @(negedge clk); cache_enable = 1'b1;
        cfetch(A, 1, "R10 set cleared (A)");
        cfetch(B, 1, "R10 set cleared (B)");

        // R11 invalidate raised during refill waits for idle
        fetch(H, 1'b0, 1'b0, -1, 1, 1'b1, H);
        chk(r_inv_early == 0, "R11 no ack during refill", 32'(r_inv_early), 0);
        chk(r_data == memw(H), "R11 fetch data", r_data, memw(H));
        @(negedge clk); #1;
        chk(inv_ack == 1 && f_ready == 0, "R11 ack in first idle cycle", {inv_ack, f_ready}, 32'h2);
        @(posedge clk); #1; inv_req = 1'b0;
        cfetch(H, 1, "R11 deferred invalidate applied");

        // random phase
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            bit inh;
            int lat;
            a   = {22'd0, 2'($urandom % 4), 4'($urandom % NSETS), 2'($urandom % WORDS), 2'b00};
            inh = ($urandom % 10) == 0;
            lat = $urandom % 3;
            if (($urandom % 12) == 0) do_inv({22'd0, 2'($urandom % 4), 4'($urandom % NSETS), 4'd0});
            fetch(a, inh, inh, -1, lat, 1'b0, 32'h0);
            chk(r_data == memw(a) && !r_err, "R5 random data", r_data, memw(a));
            if (inh) begin
                chk(r_nack == 1 && r_order_ok && !r_hit && !r_miss, "R2 random bypass", 32'(r_nack), 1);
            end else if (r_hit) begin
                chk(!r_miss && r_nack == 0 && r_k == HIT_LAT, "R3 random hit", 32'(r_k), HIT_LAT);
            end else begin
                chk(r_miss && r_nack == WORDS && r_order_ok, "R4 random refill", 32'(r_nack), WORDS);
                chk(r_k == r_last + 1, "R5 random fill timing", 32'(r_k), 32'(r_last + 1));
            end
        end

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule